// File: doc/BRIEF.md
# Buffered Asynchronous Serial Channel

This block is a full-duplex asynchronous serial port for a host link. The transmit and receive halves each run from their own clock-enable strobe, and each strobe ticks at sixteen times the bit rate. Software uses a small register interface to set the character format. The length can be 5 to 8 data bits, parity can be none, even or odd, and there can be one or two stop bits. Characters waiting to go out sit in a 128-entry queue. Received characters wait in a 256-entry queue until software reads them.

The channel raises a level interrupt request. It also sits in a priority chain. An enable comes in from the device above, and the channel passes an enable on to the devices below, such as a periodic timer. While this channel is pending or being serviced, it blocks the devices below it.

Registers are selected by `addr`:
- 0: data. A write queues a character for transmission. A read returns the oldest received character and removes it.
- 1: configuration.
- 2: status. A write of any value clears the error flags.

Reads are combinational. A register access takes effect on the clock edge where `wrEn` or `rdEn` is high.

Top module: `serial_channel`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0, `ieo` equals `iei`, configuration reads 0x00 and status reads 0x04.
- R2: The transmitter sends each queued character as one frame:
  - a low start bit;
  - the data bits, least significant first;
  - the parity bit, if parity is enabled;
  - one stop bit, or two when configuration bit 4 is 1.
  Each bit lasts 16 `txTick` strobes, and bits above the configured length are not sent.
- R3: Configuration bits [1:0] set the character length to 5 plus their value.
- R4: Configuration bits [3:2] select parity: 1 is even, 2 is odd, and 0 or 3 means no parity bit.
- R5: The receiver works on `rxTick` strobes:
  - it detects a start bit as a high-to-low change on `rxd`;
  - it confirms the start bit 8 ticks later;
  - it samples each later bit every 16 ticks;
  - it stores the character right-aligned, with zeros above the character length.
  Status bit 0 is 1 while the receive queue holds a character.
- R6: Two error flags are sticky until cleared by a write to address 2:
  - a received parity bit that does not match sets status bit 3;
  - a low first stop bit sets status bit 4.
- R7: The transmit queue holds 128 characters, and status bit 1 reports it full. A write to a full queue is dropped. Status bit 2 reports the queue empty.
- R8: The receive queue holds 256 characters. A character that arrives while the queue is full is discarded and sets sticky status bit 5.
- R9: The channel is pending when either of these holds:
  - configuration bit 5 is 1 and a received character is waiting;
  - configuration bit 6 is 1 and the transmit queue is empty.
  `irq` is high when the channel is pending, `iei` is high and no interrupt is under service.
- R10: `ieo` is high only when `iei` is high and the channel is neither pending nor under service. An `intAck` pulse while `irq` is high marks the interrupt as under service. An `intDone` pulse ends service.
- R11: `txd` changes only on a clock edge where `txTick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txTick | input | 1 | Transmit oversampling enable, 16 per bit |
| rxTick | input | 1 | Receive oversampling enable, 16 per bit |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops the receive queue at address 0) |
| addr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| iei | input | 1 | Priority chain enable from the device above |
| intAck | input | 1 | Interrupt acknowledge pulse |
| intDone | input | 1 | End-of-service pulse |
| irq | output | 1 | Level interrupt request |
| ieo | output | 1 | Priority chain enable to the devices below |

## Verification
Most faults in the bit-timing counters show up on the first frame. A wrong transmit counter shifts every later bit sample at the monitor within one character. A wrong receive state delivers a wrongly aligned character, or sets a spurious parity or framing flag, one frame after the bad sample. Queue pointer or count errors may stay hidden until a queue wraps or fills. For that reason the bench fills both queues completely, then compares the full drained sequence and the full and overrun flags. A stuck service flag shows at `ieo` in the cycle after `intAck` or `intDone`.

// File: rtl/serial_pkg.sv
package serial_pkg;
  // Configuration register, packed MSB first to match write-data bits [6:0]
  typedef struct packed {
    logic       txIe;
    logic       rxIe;
    logic       stop2;
    logic [1:0] parMode;
    logic [1:0] lenCode;
  } cfg_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxBit;
    logic rxParity;
    logic rxStop;
  } strobe_t;

  localparam int FRAME_W = 12;

  function automatic logic parOn(cfg_t c);
    return (c.parMode == 2'd1) || (c.parMode == 2'd2);
  endfunction
endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (!doPush && doPop) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/serial_dp.sv
module serial_dp import serial_pkg::*; #(
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxd,
  output logic       txd,
  input  strobe_t    stb,
  output cfg_t       cfg,
  output logic       rxLine,
  output logic       txAvail,
  output logic       txFull,
  output logic       rxFull,
  output logic       overrun,
  output logic       intReq
);
  logic [7:0] txHead, rxHead, rxShift, rxData, txChar, lenMask;
  logic [2:0] dropBits;
  logic [3:0] nBits;
  logic txEmpty, rxEmpty, rxS1, txPar, rxParExp;
  logic parErr, frameErr, errClr;
  logic [FRAME_W-1:0] txFrame, newFrame;

  assign dropBits = 3'd3 - {1'b0, cfg.lenCode};
  assign nBits    = {2'b00, cfg.lenCode} + 4'd5;
  assign lenMask  = 8'hFF >> dropBits;
  assign txChar   = txHead & lenMask;
  assign txPar    = (^txChar) ^ (cfg.parMode == 2'd2);
  assign rxData   = rxShift >> dropBits;
  assign rxParExp = (^rxData) ^ (cfg.parMode == 2'd2);
  assign txd      = txFrame[0];
  assign txAvail  = !txEmpty;
  assign errClr   = wrEn && (addr == 2'd2);
  assign intReq   = (cfg.rxIe && !rxEmpty) || (cfg.txIe && txEmpty);

  serial_fifo #(.DEPTH(TX_DEPTH), .W(8)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(wrEn && (addr == 2'd0)), .pop(stb.txLoad),
    .din(wrData), .dout(txHead), .full(txFull), .empty(txEmpty));

  serial_fifo #(.DEPTH(RX_DEPTH), .W(8)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(stb.rxStop), .pop(rdEn && (addr == 2'd0)),
    .din(rxData), .dout(rxHead), .full(rxFull), .empty(rxEmpty));

  always_comb begin
    newFrame    = '1;
    newFrame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nBits)) newFrame[i+1] = txChar[i];
    if (parOn(cfg)) newFrame[nBits + 4'd1] = txPar;
  end

  always_comb begin
    case (addr)
      2'd0:    rdData = rxHead;
      2'd1:    rdData = {1'b0, cfg};
      2'd2:    rdData = {2'b00, overrun, frameErr, parErr, txEmpty, txFull, !rxEmpty};
      default: rdData = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      txFrame  <= '1;
      rxS1     <= 1'b1;
      rxLine   <= 1'b1;
      rxShift  <= '0;
      parErr   <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      rxS1   <= rxd;
      rxLine <= rxS1;
      if (wrEn && addr == 2'd1) cfg <= cfg_t'(wrData[6:0]);
      if (stb.txLoad)       txFrame <= newFrame;
      else if (stb.txShift) txFrame <= {1'b1, txFrame[FRAME_W-1:1]};
      if (stb.rxBit) rxShift <= {rxLine, rxShift[7:1]};
      if (stb.rxParity && (rxLine != rxParExp)) parErr <= 1'b1;
      else if (errClr)                          parErr <= 1'b0;
      if (stb.rxStop && !rxLine) frameErr <= 1'b1;
      else if (errClr)           frameErr <= 1'b0;
      if (stb.rxStop && rxFull) overrun <= 1'b1;
      else if (errClr)          overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_ctrl.sv
module serial_ctrl import serial_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    txTick,
  input  logic    rxTick,
  input  cfg_t    cfg,
  input  logic    txAvail,
  input  logic    rxLine,
  input  logic    intReq,
  input  logic    iei,
  input  logic    intAck,
  input  logic    intDone,
  output strobe_t stb,
  output logic    irq,
  output logic    ieo
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rxState_t;

  rxState_t   rxState;
  logic       txBusy, rxLast, inService, bitEnd;
  logic [3:0] txCnt, txLeft, rxCnt, frameBits;
  logic [2:0] rxIdx, lastIdx;

  assign frameBits = 4'd6 + {2'b00, cfg.lenCode} + {3'b000, parOn(cfg)} +
                     (cfg.stop2 ? 4'd2 : 4'd1);
  assign lastIdx   = {1'b0, cfg.lenCode} + 3'd4;
  assign bitEnd    = rxTick && (rxCnt == 4'd15);

  assign stb.txLoad   = txTick && !txBusy && txAvail;
  assign stb.txShift  = txTick && txBusy && (txCnt == 4'd15);
  assign stb.rxBit    = bitEnd && (rxState == RX_DATA);
  assign stb.rxParity = bitEnd && (rxState == RX_PAR);
  assign stb.rxStop   = bitEnd && (rxState == RX_STOP);

  assign irq = intReq && iei && !inService;
  assign ieo = iei && !(intReq || inService);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
      txLeft <= '0;
    end else if (stb.txLoad) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
      txLeft <= frameBits;
    end else if (txTick && txBusy) begin
      txCnt <= txCnt + 1'b1;
      if (stb.txShift) begin
        txLeft <= txLeft - 1'b1;
        if (txLeft == 4'd1) txBusy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
      rxLast  <= 1'b1;
    end else if (rxTick) begin
      rxLast <= rxLine;
      case (rxState)
        RX_IDLE: if (rxLast && !rxLine) begin
          rxState <= RX_START;
          rxCnt   <= '0;
        end
        RX_START: if (rxCnt == 4'd7) begin
          rxState <= rxLine ? RX_IDLE : RX_DATA;
          rxCnt   <= '0;
          rxIdx   <= '0;
        end else rxCnt <= rxCnt + 1'b1;
        RX_DATA: begin
          rxCnt <= rxCnt + 1'b1;
          if (bitEnd) begin
            if (rxIdx == lastIdx) rxState <= parOn(cfg) ? RX_PAR : RX_STOP;
            else rxIdx <= rxIdx + 1'b1;
          end
        end
        RX_PAR: begin
          rxCnt <= rxCnt + 1'b1;
          if (bitEnd) rxState <= RX_STOP;
        end
        RX_STOP: begin
          rxCnt <= rxCnt + 1'b1;
          if (bitEnd) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  inService <= 1'b0;
    else if (intDone)           inService <= 1'b0;
    else if (intAck && irq)     inService <= 1'b1;
  end
endmodule

// File: rtl/serial_channel.sv
module serial_channel import serial_pkg::*; #(
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txTick,
  input  logic       rxTick,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       txd,
  input  logic       rxd,
  input  logic       iei,
  input  logic       intAck,
  input  logic       intDone,
  output logic       irq,
  output logic       ieo
);
  strobe_t stb;
  cfg_t    cfg;
  logic    rxLine, txAvail, txFull, rxFull, overrun, intReq;

  serial_dp #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxd(rxd), .txd(txd), .stb(stb),
    .cfg(cfg), .rxLine(rxLine), .txAvail(txAvail), .txFull(txFull),
    .rxFull(rxFull), .overrun(overrun), .intReq(intReq));

  serial_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .txTick(txTick), .rxTick(rxTick), .cfg(cfg),
    .txAvail(txAvail), .rxLine(rxLine), .intReq(intReq), .iei(iei),
    .intAck(intAck), .intDone(intDone), .stb(stb), .irq(irq), .ieo(ieo));
endmodule

// File: rtl/serial_channel_chk.sv
module serial_channel_chk (
  input logic clk,
  input logic rstN,
  input logic txTick,
  input logic txd,
  input logic iei,
  input logic irq,
  input logic ieo,
  input logic txFull,
  input logic txLoad,
  input logic rxFull,
  input logic overrun
);
  p_txd_on_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(txTick) |-> $stable(txd));

  p_chain_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    ieo |-> (iei && !irq));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> iei);

  p_overrun_when_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull));

  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && !txLoad) |=> txFull);
endmodule

bind serial_channel serial_channel_chk uChk (
  .clk(clk), .rstN(rstN), .txTick(txTick), .txd(txd), .iei(iei), .irq(irq),
  .ieo(ieo), .txFull(txFull), .txLoad(stb.txLoad), .rxFull(rxFull),
  .overrun(overrun));

// File: tb/tb_serial_channel.sv
module tb_serial_channel;
  logic clk = 0, rstN = 0, txTick = 0, rxTick = 1, wrEn = 0, rdEn = 0;
  logic [1:0] addr = 0;
  logic [7:0] wrData = 0, rdData;
  logic txd, rxd = 1, iei = 1, intAck = 0, intDone = 0, irq, ieo;
  bit   txRun = 0, finished = 0;
  int   checks = 0, fails = 0;

  typedef struct { logic [11:0] bits; int len; } frame_t;
  frame_t expQ[$];
  int bLen = 5, bPar = 0; bit bStop2 = 0;

  serial_channel dut (.clk(clk), .rstN(rstN), .txTick(txTick), .rxTick(rxTick),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .txd(txd), .rxd(rxd), .iei(iei), .intAck(intAck), .intDone(intDone),
    .irq(irq), .ieo(ieo));

  always #2 clk = ~clk;
  always @(negedge clk) txTick <= txRun ? ~txTick : 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic readReg(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rdEn = 1; #1 v = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  // cfg byte: [1:0] len-5, [3:2] parity (1 even, 2 odd), [4] two stops, [5] rxIe, [6] txIe
  task automatic setCfg(int len, int par, bit s2, bit rie, bit tie);
    bLen = len; bPar = par; bStop2 = s2;
    writeReg(2'd1, {1'b0, tie, rie, s2, 2'(par), 2'(len - 5)});
  endtask

  function automatic frame_t mkFrame(logic [7:0] d, int n, int par, bit s2);
    frame_t f; logic p = 0;
    f.bits = '1; f.bits[0] = 0;
    for (int i = 0; i < n; i++) begin f.bits[1+i] = d[i]; p ^= d[i]; end
    f.len = 1 + n + (s2 ? 2 : 1);
    if (par == 1 || par == 2) begin f.bits[1+n] = p ^ (par == 2); f.len++; end
    return f;
  endfunction

  task automatic sendTx(logic [7:0] d, bit kept);
    writeReg(2'd0, d);
    if (kept) expQ.push_back(mkFrame(d, bLen, bPar, bStop2));
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (80) @(negedge clk);
  endtask

  task automatic sendRx(logic [7:0] d, bit badPar, bit badStop);
    frame_t f = mkFrame(d, bLen, bPar, bStop2);
    if (badPar) f.bits[1+bLen] = ~f.bits[1+bLen];
    if (badStop) f.bits[f.len - (bStop2 ? 2 : 1)] = 0;
    for (int i = 0; i < f.len; i++) begin
      @(negedge clk); rxd = f.bits[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rxd = 1;
    repeat (3) @(negedge clk);
  endtask

  // Transmit monitor: scoreboard against the expected-frame queue (R2, R3, R4)
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txd === 1'b0) begin
        frame_t e; logic [11:0] got = '1; bit ok = 1;
        if (expQ.size() == 0) begin
          check(0, "R2 unexpected frame", 0, 1);
          repeat (32) @(negedge clk);
        end else begin
          e = expQ.pop_front();
          repeat (16) @(negedge clk);
          got[0] = txd;
          for (int i = 1; i < e.len; i++) begin
            repeat (32) @(negedge clk);
            got[i] = txd;
          end
          for (int i = 0; i < e.len; i++) if (got[i] !== e.bits[i]) ok = 0;
          check(ok, "R2/R3/R4 tx frame", int'(got), int'(e.bits));
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    endRun();
  end

  initial begin
    logic [7:0] v;
    int bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 txd idle", txd, 1);
    check(irq === 1'b0, "R1 irq", irq, 0);
    check(ieo === 1'b1, "R1 ieo", ieo, 1);
    readReg(2'd2, v); check(v === 8'h04, "R1 status", v, 8'h04);
    readReg(2'd1, v); check(v === 8'h00, "R1 cfg", v, 8'h00);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(txd === 1'b1, "R1 txd after reset", txd, 1);

    // R2/R3 8N1, R4 7E2 and 5O1 transmit
    txRun = 1;
    setCfg(8, 0, 0, 0, 0); sendTx(8'hA5, 1); sendTx(8'h3C, 1); waitDrain();
    setCfg(7, 1, 1, 0, 0); sendTx(8'h55, 1); sendTx(8'hFF, 1); waitDrain();
    setCfg(5, 2, 0, 0, 0); sendTx(8'h13, 1); waitDrain();

    // R5 receive 8N1
    setCfg(8, 0, 0, 0, 0);
    sendRx(8'h9A, 0, 0);
    readReg(2'd2, v); check(v[0] === 1'b1, "R5 rx ready", v[0], 1);
    readReg(2'd0, v); check(v === 8'h9A, "R5 rx data", v, 8'h9A);
    readReg(2'd2, v); check(v[0] === 1'b0, "R5 rx empty", v[0], 0);
    // R4/R6 even parity, good then bad
    setCfg(7, 1, 0, 0, 0);
    sendRx(8'h2B, 0, 0);
    readReg(2'd0, v); check(v === 8'h2B, "R3 7-bit rx data", v, 8'h2B);
    readReg(2'd2, v); check(v[3] === 1'b0, "R6 no parity error", v[3], 0);
    sendRx(8'h11, 1, 0);
    readReg(2'd0, v); check(v === 8'h11, "R6 data kept on parity error", v, 8'h11);
    readReg(2'd2, v); check(v[3] === 1'b1, "R6 parity error", v[3], 1);
    writeReg(2'd2, 8'h00);
    readReg(2'd2, v); check(v[3] === 1'b0, "R6 parity error cleared", v[3], 0);
    // R6 framing
    setCfg(8, 0, 0, 0, 0);
    sendRx(8'h40, 0, 1);
    readReg(2'd2, v); check(v[4] === 1'b1, "R6 framing error", v[4], 1);
    readReg(2'd0, v);
    writeReg(2'd2, 8'h00);
    readReg(2'd2, v); check(v[4] === 1'b0, "R6 framing cleared", v[4], 0);
    // R4 odd parity, 6 bits, two stops; R5 right-aligned with zero upper bits
    setCfg(6, 2, 1, 0, 0);
    sendRx(8'hE1, 0, 0);
    readReg(2'd0, v); check(v === 8'h21, "R5 6-bit rx data", v, 8'h21);
    readReg(2'd2, v); check(v[3] === 1'b0, "R4 odd parity ok", v[3], 0);

    // R9/R10 interrupt chain
    setCfg(8, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    check(irq === 1'b0 && ieo === 1'b1, "R9 idle no request", {irq, ieo}, 2'b01);
    sendRx(8'h77, 0, 0);
    check(irq === 1'b1 && ieo === 1'b0, "R9 request", {irq, ieo}, 2'b10);
    iei = 0; #1;
    check(irq === 1'b0 && ieo === 1'b0, "R10 blocked from above", {irq, ieo}, 2'b00);
    @(negedge clk); iei = 1; intAck = 1;
    @(negedge clk); intAck = 0;
    check(irq === 1'b0 && ieo === 1'b0, "R10 under service", {irq, ieo}, 2'b00);
    readReg(2'd0, v);
    check(ieo === 1'b0, "R10 service holds chain", ieo, 0);
    @(negedge clk); intDone = 1;
    @(negedge clk); intDone = 0;
    check(ieo === 1'b1 && irq === 1'b0, "R10 service ended", {irq, ieo}, 2'b01);
    setCfg(8, 0, 0, 0, 1);
    @(negedge clk);
    check(irq === 1'b1, "R9 tx-empty request", irq, 1);
    setCfg(5, 0, 0, 0, 0);

    // R7 transmit queue fill with ticks halted
    txRun = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 130; i++) sendTx(8'(i * 7), i < 128);
    readReg(2'd2, v);
    check(v[1] === 1'b1 && v[2] === 1'b0, "R7 tx full", v[2:1], 2'b01);
    txRun = 1;
    waitDrain();
    readReg(2'd2, v);
    check(v[2:1] === 2'b10, "R7 tx drained", v[2:1], 2'b10);

    // R8 receive queue fill and overrun
    for (int i = 0; i < 257; i++) sendRx(8'(i), 0, 0);
    readReg(2'd2, v);
    check(v[5] === 1'b1 && v[0] === 1'b1, "R8 overrun", {v[5], v[0]}, 2'b11);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      readReg(2'd0, v);
      if (v !== 8'(i & 31)) bad++;
    end
    check(bad == 0, "R8 queue contents", bad, 0);
    readReg(2'd2, v);
    check(v[0] === 1'b0, "R8 queue emptied", v[0], 0);

    endRun();
  end
endmodule